// File: doc/BRIEF.md
# Two-Level Pad Function Selector with Keyed Write Protection

The block chooses, for every general-purpose pad, which on-chip function drives it, and holds the pad's pull and drive-strength settings. Two register banks hold one configuration word per pad. The first-level word carries a 4-bit function code plus the pad controls. One reserved first-level code passes the choice to the matching second-level word, which offers a wider set of functions. The second bank also holds two small selectors that route each management-data (MDIO) channel to one of eight sources.

Each bank is guarded by its own protect register. A bank accepts configuration writes only after software writes a key to it: the bank's own absolute protect address with bit 0 set. Any other value written there closes the bank again. The block resolves the two levels into one 7-bit function code per pad. That code is registered and presented on flat output vectors together with the pad controls and the MDIO selections.

The bus is a plain word-addressed read/write port. Address bit 12 picks the bank and bits 11:0 are the byte offset inside it. Pad word n sits at offset 4*n, the protect register at 0x400, and the two MDIO selectors at 0x404 and 0x408 in the second bank.

Top module: `padmux_ctrl`

## Requirements
- R1: After reset every configuration word and MDIO selector is zero and both banks are locked. Every pad's function, pull and drive outputs read 0, and both protect registers read 0.
- R2: Writing (bank base + 0x400) | 1 to a bank's protect register (offset 0x400) unlocks that bank. Writing any other value locks it. Reading a protect register returns 1 in bit 0 when the bank is unlocked, and 0 in every other bit.
- R3: While a bank is locked, writes to its pad words and to the MDIO selectors are ignored. Reads still return the stored values.
- R4: The banks lock independently. One bank's key written to the other bank leaves that other bank locked. Unlocking one bank does not open the other.
- R5: First-level word layout: bits 3:0 function, bits 9:8 pull (0 none, 1 up, 3 down), bits 11:10 drive (0..3 for 4, 6, 8, 12 mA). Bits 11:0 are stored and read back; bits 31:12 read 0. Pull and drive codes appear unchanged on pin_pull_o and pin_drive_o.
- R6: The resolved 7-bit function equals the first-level code when that code is 0..9. When the code is 0xF, the resolved function equals 10 plus the second-level word bits 5:0. Second-level words store and read back bits 5:0 only.
- R7: First-level codes 10..14 are reserved and resolve to 10, the same code as high impedance (code 0xF with second-level value 0).
- R8: Second-bank offsets 0x404 and 0x408 hold 3-bit sources for MDIO channels 0 and 1. They appear on mdio_sel_o bits 2:0 and 5:3 and are read back in bits 2:0.
- R9: Read data appears on rd_data on the clock edge that samples rd_en and holds until the next read. Offsets that map to nothing (pad index at or beyond the pad count, the MDIO offsets in the first bank, any other offset) read 0 and ignore writes.
- R10: A pad word write changes that pad's outputs on the second rising edge counted from the write edge, not on the write edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 13 | Bit 12 bank select (0 first level, 1 second level), bits 11:0 byte offset |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_fn_o | output | NUM_PINS*7 | Resolved function per pad, pad n at bits 7n+6:7n |
| pin_pull_o | output | NUM_PINS*2 | Pull code per pad |
| pin_drive_o | output | NUM_PINS*2 | Drive-strength code per pad |
| mdio_sel_o | output | 6 | MDIO channel source selects |

## Verification
The bench goes after the keyed protection. It tries writes while a bank is locked, writes the first bank's key into the second bank, and relocks with a wrong value. A design that ignored the lock, or shared one lock between the banks, would show changed pad outputs or nonzero readback. Resolution is tested at its edges: codes 9, 10, 14 and 15, second-level values 0, 61 and 63, and the first and last pads. A decoder that let reserved codes through or misplaced the offset of 10 would give a wrong function code. It also checks the read-back of out-of-range pad indices and the two-edge output latency, which catch off-by-one decoding and a missing or extra pipeline stage.

// File: rtl/padmux_pkg.sv
package padmux_pkg;
  localparam int BUS_W      = 32;
  localparam int OFS_W      = 12;
  localparam int FN_OUT_W   = 7;
  localparam int L1_WORD_W  = 12;
  localparam int L2_WORD_W  = 6;
  localparam int MDIO_W     = 3;
  localparam int MDIO_N     = 2;
  localparam logic [OFS_W-1:0] PROT_OFS  = 12'h400;
  localparam logic [OFS_W-1:0] MDIO0_OFS = 12'h404;
  localparam logic [3:0] L1_HANDOFF = 4'hF;
  localparam logic [3:0] L1_FN_LIMIT = 4'd10;
  localparam logic [FN_OUT_W-1:0] FN_L2_BASE = 7'd10;
  localparam logic [FN_OUT_W-1:0] FN_HIZ     = 7'd10;

  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;
    logic [3:0] spare;
    logic [3:0] fn;
  } l1_word_t;
endpackage

// File: rtl/padmux_lock.sv
module padmux_lock #(
  parameter logic [31:0] KEY = 32'h0010_0400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_we,
  input  logic [31:0] wdata,
  output logic        unlocked
);
  localparam logic [31:0] OPEN_VAL = KEY | 32'd1;

  always_ff @(posedge clk) begin
    if (rst) unlocked <= 1'b0;
    else if (prot_we) unlocked <= (wdata == OPEN_VAL);
  end

  AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !unlocked); // R1
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (rst)
    (prot_we && wdata == OPEN_VAL) |=> unlocked); // R2
  AST_OTHER_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (prot_we && wdata != OPEN_VAL) |=> !unlocked); // R2
endmodule

// File: rtl/padmux_bank.sv
module padmux_bank
  import padmux_pkg::*;
#(
  parameter int NUM_PINS = 170,
  parameter int WORD_W   = 12,
  parameter logic [31:0] KEY = 32'h0010_0400
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [OFS_W-1:0]           ofs,
  input  logic [BUS_W-1:0]           wdata,
  output logic [NUM_PINS*WORD_W-1:0] cfg_flat,
  output logic [BUS_W-1:0]           rd_word,
  output logic                       unlocked
);
  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int IDX_W = OFS_W - 2;

  logic [WORD_W-1:0] mem [NUM_PINS];
  logic [IDX_W-1:0]  widx;
  logic              is_cfg, is_prot, cfg_we, prot_we;

  assign widx    = ofs[OFS_W-1:2];
  assign is_cfg  = (ofs[1:0] == 2'b00) && (widx < IDX_W'(NUM_PINS));
  assign is_prot = (ofs == PROT_OFS);
  assign cfg_we  = wr_en && is_cfg && unlocked;
  assign prot_we = wr_en && is_prot;

  padmux_lock #(.KEY(KEY)) lock_i (
    .clk(clk), .rst(rst), .prot_we(prot_we), .wdata(wdata), .unlocked(unlocked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) mem[i] <= '0;
    end else if (cfg_we) begin
      mem[widx[PIN_W-1:0]] <= wdata[WORD_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_flat
    assign cfg_flat[p*WORD_W +: WORD_W] = mem[p];
  end

  always_comb begin
    rd_word = '0;
    if (is_cfg) rd_word[WORD_W-1:0] = mem[widx[PIN_W-1:0]];
    else if (is_prot) rd_word[0] = unlocked;
  end

  AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked) |=> $stable(cfg_flat)); // R3
endmodule

// File: rtl/padmux_mdio.sv
module padmux_mdio
  import padmux_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [OFS_W-1:0]         ofs,
  input  logic [BUS_W-1:0]         wdata,
  input  logic                     unlocked,
  output logic [MDIO_N*MDIO_W-1:0] sel_flat,
  output logic [BUS_W-1:0]         rd_word
);
  logic [MDIO_N-1:0] hit;

  for (genvar k = 0; k < MDIO_N; k++) begin : g_ch
    assign hit[k] = (ofs == MDIO0_OFS + OFS_W'(4 * k));
    always_ff @(posedge clk) begin
      if (rst) sel_flat[k*MDIO_W +: MDIO_W] <= '0;
      else if (wr_en && unlocked && hit[k])
        sel_flat[k*MDIO_W +: MDIO_W] <= wdata[MDIO_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < MDIO_N; k++)
      if (hit[k]) rd_word[MDIO_W-1:0] = sel_flat[k*MDIO_W +: MDIO_W];
  end

  AST_MDIO_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !unlocked) |=> $stable(sel_flat)); // R3
endmodule

// File: rtl/padmux_resolve.sv
module padmux_resolve
  import padmux_pkg::*;
#(
  parameter int NUM_PINS = 170
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PINS*L1_WORD_W-1:0] l1_flat,
  input  logic [NUM_PINS*L2_WORD_W-1:0] l2_flat,
  output logic [NUM_PINS*FN_OUT_W-1:0]  fn_o,
  output logic [NUM_PINS*2-1:0]         pull_o,
  output logic [NUM_PINS*2-1:0]         drive_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    l1_word_t                l1;
    logic [L2_WORD_W-1:0]    l2;
    logic [FN_OUT_W-1:0]     fn_next;

    assign l1 = l1_word_t'(l1_flat[p*L1_WORD_W +: L1_WORD_W]);
    assign l2 = l2_flat[p*L2_WORD_W +: L2_WORD_W];

    always_comb begin
      if (l1.fn < L1_FN_LIMIT)       fn_next = FN_OUT_W'(l1.fn);
      else if (l1.fn == L1_HANDOFF)  fn_next = FN_L2_BASE + FN_OUT_W'(l2);
      else                           fn_next = FN_HIZ;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        fn_o[p*FN_OUT_W +: FN_OUT_W] <= '0;
        pull_o[p*2 +: 2]             <= '0;
        drive_o[p*2 +: 2]            <= '0;
      end else begin
        fn_o[p*FN_OUT_W +: FN_OUT_W] <= fn_next;
        pull_o[p*2 +: 2]             <= l1.pull;
        drive_o[p*2 +: 2]            <= l1.drive;
      end
    end

    AST_FN_RANGE: assert property (@(posedge clk) disable iff (rst)
      fn_o[p*FN_OUT_W +: FN_OUT_W] <= 7'd73); // R6
    AST_RSVD_HIZ: assert property (@(posedge clk) disable iff (rst)
      (l1.fn >= 4'd10 && l1.fn <= 4'd14) |=> (fn_o[p*FN_OUT_W +: FN_OUT_W] == FN_HIZ)); // R7
  end
endmodule

// File: rtl/padmux_ctrl.sv
module padmux_ctrl
  import padmux_pkg::*;
#(
  parameter int NUM_PINS = 170,
  parameter logic [31:0] BANK1_BASE = 32'h0010_0000,
  parameter logic [31:0] BANK2_BASE = 32'h0010_1000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [12:0]                  addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rd_data,
  output logic [NUM_PINS*FN_OUT_W-1:0] pin_fn_o,
  output logic [NUM_PINS*2-1:0]        pin_pull_o,
  output logic [NUM_PINS*2-1:0]        pin_drive_o,
  output logic [MDIO_N*MDIO_W-1:0]     mdio_sel_o
);
  localparam logic [31:0] KEY1 = BANK1_BASE + 32'(PROT_OFS);
  localparam logic [31:0] KEY2 = BANK2_BASE + 32'(PROT_OFS);

  logic [NUM_PINS*L1_WORD_W-1:0] l1_flat;
  logic [NUM_PINS*L2_WORD_W-1:0] l2_flat;
  logic [31:0] l1_rd, l2_rd, mdio_rd;
  logic        l1_open, l2_open, sel2;
  logic [OFS_W-1:0] ofs;

  assign sel2 = addr[12];
  assign ofs  = addr[OFS_W-1:0];

  padmux_bank #(.NUM_PINS(NUM_PINS), .WORD_W(L1_WORD_W), .KEY(KEY1)) bank1_i (
    .clk(clk), .rst(rst), .wr_en(wr_en && !sel2), .ofs(ofs), .wdata(wdata),
    .cfg_flat(l1_flat), .rd_word(l1_rd), .unlocked(l1_open)
  );

  padmux_bank #(.NUM_PINS(NUM_PINS), .WORD_W(L2_WORD_W), .KEY(KEY2)) bank2_i (
    .clk(clk), .rst(rst), .wr_en(wr_en && sel2), .ofs(ofs), .wdata(wdata),
    .cfg_flat(l2_flat), .rd_word(l2_rd), .unlocked(l2_open)
  );

  padmux_mdio mdio_i (
    .clk(clk), .rst(rst), .wr_en(wr_en && sel2), .ofs(ofs), .wdata(wdata),
    .unlocked(l2_open), .sel_flat(mdio_sel_o), .rd_word(mdio_rd)
  );

  padmux_resolve #(.NUM_PINS(NUM_PINS)) resolve_i (
    .clk(clk), .rst(rst), .l1_flat(l1_flat), .l2_flat(l2_flat),
    .fn_o(pin_fn_o), .pull_o(pin_pull_o), .drive_o(pin_drive_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= sel2 ? (l2_rd | mdio_rd) : l1_rd;
  end

  AST_BANKS_SEPARATE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel2 && !l2_open) |=> ($stable(l2_flat) && $stable(mdio_sel_o))); // R4
  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R9
endmodule

// File: tb/padmux_ctrl_tb_top.sv
module padmux_ctrl_tb_top;
  localparam int NP = 170;
  localparam logic [31:0] B1 = 32'h0010_0000;
  localparam logic [31:0] B2 = 32'h0010_1000;
  localparam logic [31:0] K1 = 32'h0010_0401;
  localparam logic [31:0] K2 = 32'h0010_1401;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [12:0] addr = '0;
  logic [31:0] wdata = '0, rd_data;
  logic [NP*7-1:0] pin_fn_o;
  logic [NP*2-1:0] pin_pull_o, pin_drive_o;
  logic [5:0] mdio_sel_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  padmux_ctrl #(.NUM_PINS(NP), .BANK1_BASE(B1), .BANK2_BASE(B2)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .pin_fn_o(pin_fn_o),
    .pin_pull_o(pin_pull_o), .pin_drive_o(pin_drive_o), .mdio_sel_o(mdio_sel_o)
  );

  // pin[31:24] l1 code[19:16] l2 value[13:8] expected fn[6:0]
  localparam logic [31:0] VEC [10] = '{
    32'h00_03_00_03, 32'h01_09_00_09, 32'h02_0F_00_0A, 32'h03_0F_3D_47,
    32'h04_0C_05_0A, 32'h05_0E_00_0A, 32'h06_00_07_00, 32'hA9_0F_3F_49,
    32'h07_0A_11_0A, 32'h08_0F_12_1C
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic bank, input logic [11:0] ofs, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = {bank, ofs}; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic bank, input logic [11:0] ofs, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = {bank, ofs};
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  function automatic logic [31:0] fn_of(input int p);
    return 32'(pin_fn_o[p*7 +: 7]);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 fn pin0", fn_of(0), 0);
    chk("R1 fn pin169", fn_of(169), 0);
    chk("R1 pull/drive", 32'(|{pin_pull_o, pin_drive_o}), 0);
    chk("R1 mdio", 32'(mdio_sel_o), 0);
    bus_rd(0, 12'h400, r); chk("R1 prot1 locked", r, 0);
    bus_rd(1, 12'h400, r); chk("R1 prot2 locked", r, 0);

    // R3 locked writes ignored
    bus_wr(0, 12'h014, 32'h3); @(negedge clk);
    chk("R3 locked fn", fn_of(5), 0);
    bus_rd(0, 12'h014, r); chk("R3 locked readback", r, 0);
    bus_wr(1, 12'h404, 32'h5); @(negedge clk);
    chk("R3 locked mdio", 32'(mdio_sel_o), 0);

    // R4 wrong-bank key, independent unlock
    bus_wr(1, 12'h400, K1);
    bus_rd(1, 12'h400, r); chk("R4 foreign key", r, 0);
    bus_wr(0, 12'h400, K1);
    bus_rd(0, 12'h400, r); chk("R2 prot1 open", r, 1);
    bus_rd(1, 12'h400, r); chk("R4 prot2 still locked", r, 0);
    bus_wr(1, 12'h000, 32'h5);
    bus_rd(1, 12'h000, r); chk("R4 l2 write ignored", r, 0);
    bus_wr(1, 12'h400, K2);
    bus_rd(1, 12'h400, r); chk("R2 prot2 open", r, 1);

    // R6 R7 vector table
    foreach (VEC[i]) begin
      int p;
      p = int'(VEC[i][31:24]);
      bus_wr(1, 12'(p * 4), 32'(VEC[i][13:8]));
      bus_wr(0, 12'(p * 4), 32'(VEC[i][19:16]));
      @(negedge clk);
      chk("R6/R7 resolve", fn_of(p), 32'(VEC[i][6:0]));
    end
    bus_rd(1, 12'h0C, r); chk("R6 l2 readback", r, 32'h3D);
    bus_wr(1, 12'h0C, 32'hFFFF_FFC7);
    bus_rd(1, 12'h0C, r); chk("R6 l2 upper bits dropped", r, 32'h07);

    // R5 layout and pad controls
    bus_wr(0, 12'h024, 32'hFFFF_FD02); @(negedge clk);
    chk("R5 fn", fn_of(9), 2);
    chk("R5 pull up", 32'(pin_pull_o[18 +: 2]), 1);
    chk("R5 drive 12mA", 32'(pin_drive_o[18 +: 2]), 3);
    bus_rd(0, 12'h024, r); chk("R5 readback", r, 32'hD02);
    bus_wr(0, 12'h028, 32'h0000_0300); @(negedge clk);
    chk("R5 pull down", 32'(pin_pull_o[20 +: 2]), 3);
    chk("R5 drive 4mA", 32'(pin_drive_o[20 +: 2]), 0);

    // R8 MDIO selectors
    bus_wr(1, 12'h404, 32'h5);
    bus_wr(1, 12'h408, 32'hF);
    chk("R8 mdio out", 32'(mdio_sel_o), 32'h3D);
    bus_rd(1, 12'h408, r); chk("R8 mdio1 readback", r, 7);
    bus_rd(1, 12'h404, r); chk("R8 mdio0 readback", r, 5);

    // R9 unmapped offsets
    bus_wr(0, 12'h2A8, 32'h3);
    bus_rd(0, 12'h2A8, r); chk("R9 pad 170 absent", r, 0);
    bus_rd(0, 12'h404, r); chk("R9 no mdio in bank1", r, 0);
    bus_wr(1, 12'h40C, 32'h7);
    bus_rd(1, 12'h40C, r); chk("R9 offset 0x40C", r, 0);
    chk("R9 mdio untouched", 32'(mdio_sel_o), 32'h3D);
    rd_en = 1'b0; @(negedge clk); @(negedge clk);
    chk("R9 read data held", rd_data, 0);

    // R10 latency
    bus_wr(0, 12'h030, 32'h4);
    chk("R10 not yet", fn_of(12), 0);
    @(negedge clk);
    chk("R10 second edge", fn_of(12), 4);

    // R2 relock with wrong value, R3 ignored afterwards
    bus_wr(0, 12'h400, 32'h0010_0400);
    bus_rd(0, 12'h400, r); chk("R2 relock", r, 0);
    bus_wr(0, 12'h030, 32'h6); @(negedge clk);
    chk("R3 relocked ignore", fn_of(12), 4);
    bus_rd(0, 12'h030, r); chk("R3 stored read", r, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule